// File: doc/BRIEF.md
# Reset Cause and Software Reset Trigger Register

This block holds one 32-bit word that tells software why the system last went through reset, and lets software ask for a new reset. Three status flags record a power-on event, a power-on button press and an external-reset button press. Two trigger flags record that software itself asked for a power-on style reset or for an externally-initiated style reset. Status flags are cleared by writing ones. Trigger flags are set by writing ones, and a trigger write raises a one-cycle reset request on the output that matches the requested kind.

A power-up indication input marks the register as not yet initialised. The first system reset after that loads the word with only the power-on status flag set. Every later system reset leaves the contents alone, so software can read the cause after the reset is over. Creating the reset itself and sequencing clocks are left to the surrounding logic.

Top module: `rst_cause_reg`

## Requirements
- R1: Bits 26 down to 0 of `rd_data` always read as zero, whatever is written.
- R2: While `pwr_up` is high the register reads zero and no request is raised; the first clock edge with `sys_rst` high after `pwr_up` falls loads the word 0x80000000 (bit 31 only).
- R3: A system reset that is not the first one after power-up keeps the register contents unchanged.
- R4: A write with a one in bit 31, 28 or 27 clears that bit; zeros in those positions leave the bits unchanged.
- R5: A write with a one in bit 30 or 29 sets that bit; a zero there leaves the bit unchanged, so software cannot clear it.
- R6: A write with bit 30 set raises `req_por` in the cycle after the write and keeps `req_xir` low, even when bit 29 is also set.
- R7: A write with bit 29 set and bit 30 clear raises `req_xir` in the cycle after the write, with `req_por` low.
- R8: Each request is high for a single cycle unless the next cycle also carries a trigger write, and the two requests are never high together.
- R9: `btn_por` sets bit 28 and `btn_xir` sets bit 27 at the next edge; a button set wins over a clearing write in the same cycle.
- R10: While `sys_rst` is high, writes and button inputs have no effect and no request is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| pwr_up | input | 1 | Power-up indication, high while power is coming up; clears and re-arms the register |
| sys_rst | input | 1 | System reset, synchronous, active high |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current register contents |
| btn_por | input | 1 | Power-on button event, sets bit 28 |
| btn_xir | input | 1 | External-reset button event, sets bit 27 |
| req_por | output | 1 | One-cycle request for a power-on style system reset |
| req_xir | output | 1 | One-cycle request for an externally-initiated system reset |

## Verification
The write path is tried with words that touch only clear bits, only set bits, both at once, all ones, all zeros and reserved bits alone; these tell the write-one-to-clear flags apart from the set-only flags and show that zeros and reserved positions are inert. Trigger writes with bit 30 alone, bit 29 alone and both together separate the two request kinds and their priority, and idle cycles after them show the pulse ends. Button events alone and against a same-cycle clearing write distinguish the set-wins rule. Reset sequences compare a first reset after power-up with a later one, and writes during reset show they are dropped.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

  localparam int REG_W    = 32;
  localparam int B_POR    = 31;
  localparam int B_SWPOR  = 30;
  localparam int B_SWXIR  = 29;
  localparam int B_BTNPOR = 28;
  localparam int B_BTNXIR = 27;

  localparam logic [REG_W-1:0] ONE = REG_W'(1);
  localparam logic [REG_W-1:0] W1C_MASK  = (ONE << B_POR) | (ONE << B_BTNPOR) | (ONE << B_BTNXIR);
  localparam logic [REG_W-1:0] SET_MASK  = (ONE << B_SWPOR) | (ONE << B_SWXIR);
  localparam logic [REG_W-1:0] LIVE_MASK = W1C_MASK | SET_MASK;
  localparam logic [REG_W-1:0] POR_VALUE = ONE << B_POR;

  typedef struct packed {
    logic por;
    logic xir;
  } rsc_req_t;

  // Next register value for an accepted write plus button events.
  function automatic logic [REG_W-1:0] rsc_apply(
    input logic [REG_W-1:0] cur,
    input logic             wen,
    input logic [REG_W-1:0] wdata,
    input logic             bp,
    input logic             bx
  );
    logic [REG_W-1:0] n;
    n = cur;
    if (wen) n = (n & ~(wdata & W1C_MASK)) | (wdata & SET_MASK);
    if (bp)  n[B_BTNPOR] = 1'b1;
    if (bx)  n[B_BTNXIR] = 1'b1;
    return n & LIVE_MASK;
  endfunction

  // Kind of reset requested by a write; power-on style has priority.
  function automatic rsc_req_t rsc_decode(
    input logic             wen,
    input logic [REG_W-1:0] wdata
  );
    rsc_req_t r;
    r.por = wen & wdata[B_SWPOR];
    r.xir = wen & ~wdata[B_SWPOR] & wdata[B_SWXIR];
    return r;
  endfunction

endpackage

// File: rtl/rsc_wr_decode.sv
module rsc_wr_decode
  import rsc_pkg::*;
(
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             btn_por,
  input  logic             btn_xir,
  input  logic             blocked,
  output logic             wr_accept,
  output logic [REG_W-1:0] clr_mask,
  output logic [REG_W-1:0] set_mask,
  output rsc_req_t         trig
);

  logic [REG_W-1:0] hw_set;

  always_comb begin
    wr_accept = wr_en & ~blocked;
    hw_set    = '0;
    hw_set[B_BTNPOR] = btn_por & ~blocked;
    hw_set[B_BTNXIR] = btn_xir & ~blocked;
    clr_mask  = wr_accept ? (wr_data & W1C_MASK) : '0;
    set_mask  = (wr_accept ? (wr_data & SET_MASK) : '0) | hw_set;
    trig      = rsc_decode(wr_accept, wr_data);
  end

endmodule

// File: rtl/rsc_status_reg.sv
module rsc_status_reg
  import rsc_pkg::*;
(
  input  logic             clk,
  input  logic             pwr_up,
  input  logic             sys_rst,
  input  logic [REG_W-1:0] clr_mask,
  input  logic [REG_W-1:0] set_mask,
  output logic             por_load,
  output logic [REG_W-1:0] q
);

  logic armed;

  assign por_load = sys_rst & armed & ~pwr_up;

  always_ff @(posedge clk) begin
    if (pwr_up)       armed <= 1'b1;
    else if (sys_rst) armed <= 1'b0;
  end

  for (genvar i = 0; i < REG_W; i++) begin : g_bit
    if (LIVE_MASK[i]) begin : g_live
      always_ff @(posedge clk) begin
        if (pwr_up)        q[i] <= 1'b0;
        else if (por_load) q[i] <= POR_VALUE[i];
        else if (!sys_rst) q[i] <= (q[i] & ~clr_mask[i]) | set_mask[i];
      end
    end else begin : g_rsvd
      assign q[i] = 1'b0;
    end
  end

endmodule

// File: rtl/rsc_req_pulse.sv
module rsc_req_pulse
  import rsc_pkg::*;
(
  input  logic     clk,
  input  logic     pwr_up,
  input  logic     sys_rst,
  input  rsc_req_t trig,
  output rsc_req_t req
);

  always_ff @(posedge clk) begin
    if (pwr_up || sys_rst) req <= '0;
    else                   req <= trig;
  end

endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
  import rsc_pkg::*;
(
  input  logic             clk,
  input  logic             pwr_up,
  input  logic             sys_rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             btn_por,
  input  logic             btn_xir,
  output logic             req_por,
  output logic             req_xir
);

  logic             wr_accept;
  logic             por_load;
  logic [REG_W-1:0] clr_mask;
  logic [REG_W-1:0] set_mask;
  rsc_req_t         trig;
  rsc_req_t         req;

  rsc_wr_decode u_dec (
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .btn_por   (btn_por),
    .btn_xir   (btn_xir),
    .blocked   (sys_rst | pwr_up),
    .wr_accept (wr_accept),
    .clr_mask  (clr_mask),
    .set_mask  (set_mask),
    .trig      (trig)
  );

  rsc_status_reg u_stat (
    .clk      (clk),
    .pwr_up   (pwr_up),
    .sys_rst  (sys_rst),
    .clr_mask (clr_mask),
    .set_mask (set_mask),
    .por_load (por_load),
    .q        (rd_data)
  );

  rsc_req_pulse u_req (
    .clk     (clk),
    .pwr_up  (pwr_up),
    .sys_rst (sys_rst),
    .trig    (trig),
    .req     (req)
  );

  assign req_por = req.por;
  assign req_xir = req.xir;

endmodule

// File: rtl/rst_cause_reg_chk.sv
module rst_cause_reg_chk
  import rsc_pkg::*;
(
  input logic             clk,
  input logic             pwr_up,
  input logic             sys_rst,
  input logic             wr_en,
  input logic [REG_W-1:0] wr_data,
  input logic [REG_W-1:0] rd_data,
  input logic             btn_por,
  input logic             req_por,
  input logic             req_xir,
  input logic             por_load
);

  p_reserved_zero_r1: assert property (@(posedge clk) disable iff (pwr_up)
    1'b1 |-> (rd_data & ~LIVE_MASK) == '0);

  p_first_load_r2: assert property (@(posedge clk) disable iff (pwr_up)
    por_load |=> rd_data == POR_VALUE);

  p_keep_on_reset_r3: assert property (@(posedge clk) disable iff (pwr_up)
    (sys_rst && !por_load) |=> $stable(rd_data));

  p_w1c_r4: assert property (@(posedge clk) disable iff (pwr_up || sys_rst)
    (wr_en && wr_data[B_POR]) |=> !rd_data[B_POR]);

  p_set_r5: assert property (@(posedge clk) disable iff (pwr_up || sys_rst)
    (wr_en && wr_data[B_SWPOR]) |=> rd_data[B_SWPOR]);

  p_swpor_r6: assert property (@(posedge clk) disable iff (pwr_up || sys_rst)
    (wr_en && wr_data[B_SWPOR]) |=> (req_por && !req_xir));

  p_swxir_r7: assert property (@(posedge clk) disable iff (pwr_up || sys_rst)
    (wr_en && !wr_data[B_SWPOR] && wr_data[B_SWXIR]) |=> (req_xir && !req_por));

  p_onehot_r8: assert property (@(posedge clk) disable iff (pwr_up)
    $onehot0({req_por, req_xir}));

  p_single_r8: assert property (@(posedge clk) disable iff (pwr_up)
    !(wr_en && (wr_data[B_SWPOR] || wr_data[B_SWXIR])) |=> !(req_por || req_xir));

  p_button_r9: assert property (@(posedge clk) disable iff (pwr_up || sys_rst)
    btn_por |=> rd_data[B_BTNPOR]);

  p_rst_quiet_r10: assert property (@(posedge clk) disable iff (pwr_up)
    sys_rst |=> !(req_por || req_xir));

endmodule

bind rst_cause_reg rst_cause_reg_chk u_chk (
  .clk      (clk),
  .pwr_up   (pwr_up),
  .sys_rst  (sys_rst),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .rd_data  (rd_data),
  .btn_por  (btn_por),
  .req_por  (req_por),
  .req_xir  (req_xir),
  .por_load (por_load)
);

// File: tb/tb_rst_cause_reg.sv
module tb_rst_cause_reg;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;
  localparam int VW = 3 + 32 + 32 + 2;

  // {btn_por, btn_xir, wr_en, wr_data, expected rd_data, expected req_por, expected req_xir}
  localparam logic [VW-1:0] VEC [NVEC] = '{
    {3'b001, 32'h0000_0000, 32'h8000_0000, 2'b00},  // R4 zeros inert
    {3'b001, 32'h8000_0000, 32'h0000_0000, 2'b00},  // R4 clear bit 31
    {3'b100, 32'h0000_0000, 32'h1000_0000, 2'b00},  // R9 button POR
    {3'b010, 32'h0000_0000, 32'h1800_0000, 2'b00},  // R9 button XIR
    {3'b001, 32'h0800_0000, 32'h1000_0000, 2'b00},  // R4 clear bit 27
    {3'b001, 32'h2000_0000, 32'h3000_0000, 2'b01},  // R5 R7 xir trigger
    {3'b001, 32'h07FF_FFFF, 32'h3000_0000, 2'b00},  // R1 reserved bits
    {3'b001, 32'h6000_0000, 32'h7000_0000, 2'b10},  // R6 priority
    {3'b001, 32'h0000_0000, 32'h7000_0000, 2'b00},  // R5 R8 no clear, pulse ends
    {3'b001, 32'hFFFF_FFFF, 32'h6000_0000, 2'b10},  // R4 R6 all ones
    {3'b101, 32'h1000_0000, 32'h7000_0000, 2'b00},  // R9 set wins over clear
    {3'b000, 32'hFFFF_FFFF, 32'h7000_0000, 2'b00}   // R8 no strobe
  };

  logic        clk = 1'b0;
  logic        pwr_up = 1'b1;
  logic        sys_rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        btn_por = 1'b0;
  logic        btn_xir = 1'b0;
  logic        req_por;
  logic        req_xir;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_cause_reg dut (
    .clk     (clk),
    .pwr_up  (pwr_up),
    .sys_rst (sys_rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .btn_por (btn_por),
    .btn_xir (btn_xir),
    .req_por (req_por),
    .req_xir (req_xir)
  );

  task automatic check(input string req, input logic [33:0] act, input logic [33:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual rd=%h req=%b expected rd=%h req=%b",
               req, act[33:2], act[1:0], exp[33:2], exp[1:0]);
    end
  endtask

  task automatic drive(input logic bp, input logic bx, input logic we, input logic [31:0] d);
    btn_por = bp; btn_xir = bx; wr_en = we; wr_data = d;
  endtask

  task automatic step_check(input string req, input logic [31:0] exp_rd, input logic [1:0] exp_req);
    @(negedge clk);
    check(req, {rd_data, req_por, req_xir}, {exp_rd, exp_req});
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual cycles=%0d expected completion", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R2: power-up clears the word, no requests
    repeat (3) @(negedge clk);
    check("R2 power-up", {rd_data, req_por, req_xir}, {32'h0, 2'b00});
    pwr_up = 1'b0;
    step_check("R2 first reset load", 32'h8000_0000, 2'b00);
    sys_rst = 1'b0;
    step_check("R2 load held after reset", 32'h8000_0000, 2'b00);

    // Vector table: R1 R4 R5 R6 R7 R8 R9
    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][VW-1], VEC[i][VW-2], VEC[i][VW-3], VEC[i][65:34]);
      step_check($sformatf("R1-table vector %0d", i), VEC[i][33:2], VEC[i][1:0]);
    end
    drive(1'b0, 1'b0, 1'b0, '0);

    // R6 R8: trigger pulse then idle
    drive(1'b0, 1'b0, 1'b1, 32'h4000_0000);
    step_check("R6 por request", 32'h7000_0000, 2'b10);
    drive(1'b0, 1'b0, 1'b0, '0);
    step_check("R8 pulse ends", 32'h7000_0000, 2'b00);

    // R10 R3: later reset keeps contents, ignores writes and buttons
    sys_rst = 1'b1;
    drive(1'b0, 1'b1, 1'b1, 32'hA800_0000);
    step_check("R10 write during reset", 32'h7000_0000, 2'b00);
    step_check("R3 later reset keeps", 32'h7000_0000, 2'b00);
    sys_rst = 1'b0;
    drive(1'b0, 1'b0, 1'b0, '0);
    step_check("R3 after reset release", 32'h7000_0000, 2'b00);

    // R2: power-up re-arms the first-reset load
    pwr_up = 1'b1;
    step_check("R2 power-up again", 32'h0, 2'b00);
    pwr_up = 1'b0;
    sys_rst = 1'b1;
    step_check("R2 re-armed load", 32'h8000_0000, 2'b00);
    sys_rst = 1'b0;

    // R7: xir request after reload
    drive(1'b0, 1'b0, 1'b1, 32'h2000_0000);
    step_check("R7 xir request", 32'hA000_0000, 2'b01);
    drive(1'b0, 1'b0, 1'b0, '0);
    step_check("R8 xir pulse ends", 32'hA000_0000, 2'b00);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule